// File: doc/BRIEF.md
# SPI Master with Clockless Delimiter Pulses

This block is a full-duplex SPI master for 8-bit frames. SCLK idles high, and each bit uses two edges. The first edge is falling and launches the next MOSI bit. The second edge is rising and captures MISO. Bits go out most significant first. The user side offers one byte at a time through a valid/ready handshake. A flag travels with each byte. When the flag is set, the block first drives a single low-high-low pulse on MOSI. SCLK stays at its idle high level through the whole pulse. The slave therefore sees a delimiter that carries no clock edge and cannot be taken for a data bit.

Timing is counted in system clock cycles:
- One SCLK half-period lasts `half_div_i` cycles, so a bit takes twice that. The default setting of 8 gives a divide ratio of 16, which yields 6 Mbit/s from a 96 MHz clock.
- The delimiter has three parts: a low guard, a high pulse and a second low guard. Each part has its own length input.
- Each part is stretched to at least one SCLK half-period.
- The configuration inputs are sampled whenever a phase starts. They are expected to stay stable while a byte is in flight.

The chip select is a registered copy of a software enable. The frame engine never drives it.

Top module: `spi_dlm_master`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, the outputs hold their reset values: `sclk_o`=1, `mosi_o`=0, `busy_o`=0, `tx_ready_o`=1, `rx_valid_o`=0 and `cs_n_o`=1.
- R2: During a frame, the SCLK low phase and the SCLK high phase each last `half_div_i` system clocks. A value of 0 is treated as 1.
- R3: A frame has 8 bits, with bit 7 first. `mosi_o` takes each bit as SCLK falls. It holds that bit through the following high phase.
- R4: `miso_i` is sampled at each SCLK rising edge. The eight samples form `rx_data_o`, with the first sample in bit 7.
- R5: When a byte is accepted with `tx_dlm_i`=1, three phases come before its first SCLK falling edge, with SCLK high throughout:
  - MOSI low for G cycles.
  - MOSI high for P cycles.
  - MOSI low for G cycles.
  - G is `guard_len_i` and P is `pulse_len_i`, each raised to the effective half-period if smaller.
- R6: SCLK stays high whenever no frame bit is in progress: in idle, in every delimiter phase and between frames. A frame always ends at the high level.
- R7: `rx_valid_o` is high for exactly one cycle. That cycle is the one in which SCLK has just risen for the eighth bit, and `rx_data_o` holds the received byte in it.
- R8: A byte is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is high only while the engine is idle, and `busy_o` is its complement.
  - `tx_valid_i` has no effect while the engine is busy.
  - After the last high phase of a frame the engine is idle for at least one cycle. Only then can it accept the next byte.
- R9: `cs_n_o` equals the inverse of `cs_en_i` as sampled at the previous clock edge. It does not depend on the frame engine.
- R10: `mosi_o` is low whenever neither a frame bit nor a delimiter pulse is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | DIV_W | SCLK half-period in system clocks (0 acts as 1) |
| guard_len_i | input | DLY_W | Low guard length on each side of the delimiter pulse |
| pulse_len_i | input | DLY_W | Delimiter pulse high length |
| cs_en_i | input | 1 | Software chip select request, active high |
| cs_n_o | output | 1 | Registered chip select, active low |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Engine idle, byte can be taken |
| tx_data_i | input | DATA_W | Transmit byte |
| tx_dlm_i | input | 1 | Emit a delimiter before this byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | DATA_W | Last received byte |
| busy_o | output | 1 | Delimiter or frame in progress |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions check on every cycle that idle means SCLK high and MOSI low, and that every frame ends with SCLK high. They also check that an accepted byte moves the engine out of idle, and that the receive strobe is a single cycle aligned with an SCLK rising edge. Finally they check that chip select tracks its request with one cycle of delay.

Only the bench's scenarios can show the rest:
- the exact phase lengths;
- the clamping of short or zero settings;
- the bit order in both directions;
- the placement of the delimiter pulse relative to the first falling edge;
- that a byte offered while busy is held off and not lost.

The bench covers these by comparing the pins against a waveform predicted from the configuration for several divider and delimiter settings.

// File: rtl/spi_dlm_pkg.sv
package spi_dlm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD_A,
    ST_PULSE,
    ST_GUARD_B,
    ST_BIT_LO,
    ST_BIT_HI
  } seq_st_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_dlm_timer.sv
module spi_dlm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // phase of N cycles ends when count reaches one
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/spi_dlm_shift.sv
module spi_dlm_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              miso_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_data_o
);

  logic [DATA_W-1:0] tx_q, rx_q, rx_hold_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_q[DATA_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      rx_q      <= '0;
      rx_hold_q <= '0;
    end else begin
      if (load_i) begin
        tx_q <= data_i;
      end else if (shift_i) begin
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
      if (sample_i) begin
        rx_q <= rx_next;
        if (last_i) rx_hold_q <= rx_next;
      end
    end
  end

  assign tx_bit_o  = tx_q[DATA_W-1];
  assign rx_data_o = rx_hold_q;

endmodule

// File: rtl/spi_dlm_ctrl.sv
module spi_dlm_ctrl
  import spi_dlm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [DLY_W-1:0] guard_len_i,
  input  logic [DLY_W-1:0] pulse_len_i,
  input  logic             tx_valid_i,
  input  logic             tx_dlm_i,
  input  logic             timer_last_i,
  output logic             timer_load_o,
  output logic [CNT_W-1:0] timer_len_o,
  output logic             tx_ready_o,
  output logic             busy_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             last_bit_o,
  output logic             sclk_o,
  output logic             frame_o,
  output logic             pulse_o,
  output logic             rx_valid_o
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  seq_st_e          state_q, state_d;
  logic [BIT_W-1:0] bit_q;
  logic             rx_valid_q;
  logic [CNT_W-1:0] half_raw, guard_raw, pulse_raw;
  logic [CNT_W-1:0] half_eff, guard_eff, pulse_eff;
  logic             accept;

  assign half_raw  = CNT_W'(half_div_i);
  assign guard_raw = CNT_W'(guard_len_i);
  assign pulse_raw = CNT_W'(pulse_len_i);
  assign half_eff  = (half_raw == '0) ? CNT_W'(1) : half_raw;
  assign guard_eff = (guard_raw < half_eff) ? half_eff : guard_raw;
  assign pulse_eff = (pulse_raw < half_eff) ? half_eff : pulse_raw;

  assign tx_ready_o = (state_q == ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign accept     = tx_ready_o && tx_valid_i;
  assign load_o     = accept;
  assign last_bit_o = (bit_q == LAST_BIT);

  always_comb begin
    state_d      = state_q;
    timer_load_o = 1'b0;
    timer_len_o  = half_eff;
    shift_o      = 1'b0;
    sample_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_valid_i) begin
          timer_load_o = 1'b1;
          if (tx_dlm_i) begin
            state_d     = ST_GUARD_A;
            timer_len_o = guard_eff;
          end else begin
            state_d = ST_BIT_LO;
          end
        end
      end
      ST_GUARD_A: begin
        if (timer_last_i) begin
          state_d      = ST_PULSE;
          timer_load_o = 1'b1;
          timer_len_o  = pulse_eff;
        end
      end
      ST_PULSE: begin
        if (timer_last_i) begin
          state_d      = ST_GUARD_B;
          timer_load_o = 1'b1;
          timer_len_o  = guard_eff;
        end
      end
      ST_GUARD_B: begin
        if (timer_last_i) begin
          state_d      = ST_BIT_LO;
          timer_load_o = 1'b1;
        end
      end
      ST_BIT_LO: begin
        if (timer_last_i) begin
          state_d      = ST_BIT_HI;
          timer_load_o = 1'b1;
          sample_o     = 1'b1;
        end
      end
      ST_BIT_HI: begin
        if (timer_last_i) begin
          if (last_bit_o) begin
            state_d = ST_IDLE;
          end else begin
            state_d      = ST_BIT_LO;
            timer_load_o = 1'b1;
            shift_o      = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rx_valid_q <= sample_o && last_bit_o;
      if (accept) begin
        bit_q <= '0;
      end else if (shift_o) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign sclk_o     = (state_q != ST_BIT_LO);
  assign frame_o    = (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI);
  assign pulse_o    = (state_q == ST_PULSE);
  assign rx_valid_o = rx_valid_q;

endmodule

// File: rtl/spi_dlm_master.sv
module spi_dlm_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [DLY_W-1:0]  guard_len_i,
  input  logic [DLY_W-1:0]  pulse_len_i,
  input  logic              cs_en_i,
  output logic              cs_n_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_dlm_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  localparam int CNT_W = spi_dlm_pkg::max_int(DIV_W, DLY_W);

  logic             timer_load, timer_last;
  logic [CNT_W-1:0] timer_len;
  logic             load, shift, sample, last_bit;
  logic             frame, pulse, tx_bit;
  logic             cs_n_q;

  spi_dlm_ctrl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_div_i  (half_div_i),
    .guard_len_i (guard_len_i),
    .pulse_len_i (pulse_len_i),
    .tx_valid_i  (tx_valid_i),
    .tx_dlm_i    (tx_dlm_i),
    .timer_last_i(timer_last),
    .timer_load_o(timer_load),
    .timer_len_o (timer_len),
    .tx_ready_o  (tx_ready_o),
    .busy_o      (busy_o),
    .load_o      (load),
    .shift_o     (shift),
    .sample_o    (sample),
    .last_bit_o  (last_bit),
    .sclk_o      (sclk_o),
    .frame_o     (frame),
    .pulse_o     (pulse),
    .rx_valid_o  (rx_valid_o)
  );

  spi_dlm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(timer_load),
    .len_i (timer_len),
    .last_o(timer_last)
  );

  spi_dlm_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .data_i   (tx_data_i),
    .shift_i  (shift),
    .sample_i (sample),
    .last_i   (last_bit),
    .miso_i   (miso_i),
    .tx_bit_o (tx_bit),
    .rx_data_o(rx_data_o)
  );

  // chip select is software owned, just registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_n_q <= 1'b1;
    else         cs_n_q <= ~cs_en_i;
  end

  assign cs_n_o = cs_n_q;
  assign mosi_o = frame ? tx_bit : pulse;

endmodule

// File: rtl/spi_dlm_master_chk.sv
module spi_dlm_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic busy_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic rx_valid_o,
  input logic cs_en_i,
  input logic cs_n_o
);

  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o); // R6

  AST_IDLE_MOSI_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mosi_o); // R10

  AST_FRAME_ENDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sclk_o && $past(sclk_o))); // R6

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> busy_o); // R8

  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R7

  AST_RX_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $rose(sclk_o)); // R7

  AST_CS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (cs_n_o == !$past(cs_en_i))); // R9

endmodule

bind spi_dlm_master spi_dlm_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o),
  .busy_o    (busy_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .rx_valid_o(rx_valid_o),
  .cs_en_i   (cs_en_i),
  .cs_n_o    (cs_n_o)
);

// File: tb/spi_dlm_master_tb.sv
module spi_dlm_master_tb;

  typedef struct packed {
    logic       sclk;
    logic       mosi;
    logic       rx;
    logic [7:0] rxd;
  } ent_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_div = 8'd8;
  logic [7:0] guard_len = 8'd0;
  logic [7:0] pulse_len = 8'd0;
  logic       cs_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_dlm = 1'b0;
  logic       miso = 1'b0;
  logic       cs_n, tx_ready, rx_valid, busy, sclk, mosi;
  logic [7:0] rx_data;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   frame_n = 0;
  logic exp_cs_n = 1'b1;
  ent_t exp_q[$];
  logic [7:0] sent_q[$];

  always #10 clk = ~clk;

  spi_dlm_master u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .half_div_i(half_div), .guard_len_i(guard_len), .pulse_len_i(pulse_len),
    .cs_en_i(cs_en), .cs_n_o(cs_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data), .tx_dlm_i(tx_dlm),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .busy_o(busy),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  function automatic logic [7:0] slave_byte(input int n);
    return 8'((n * 29 + 107) % 256);
  endfunction

  function automatic ent_t mk(input logic s, input logic m, input logic r, input logic [7:0] d);
    ent_t e;
    e.sclk = s; e.mosi = m; e.rx = r; e.rxd = d;
    return e;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // reference waveform model: one entry per busy cycle
  always @(posedge clk) begin
    if (rst_n) begin
      exp_cs_n = !cs_en;
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
      end else if (tx_valid) begin
        int h, g, p;
        logic [7:0] sb;
        h  = (half_div == 0) ? 1 : int'(half_div);
        g  = (int'(guard_len) > h) ? int'(guard_len) : h;
        p  = (int'(pulse_len) > h) ? int'(pulse_len) : h;
        sb = slave_byte(frame_n);
        frame_n++;
        sent_q.push_back(tx_data);
        if (tx_dlm) begin
          repeat (g) exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 8'h00));
          repeat (p) exp_q.push_back(mk(1'b1, 1'b1, 1'b0, 8'h00));
          repeat (g) exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 8'h00));
        end
        for (int b = 7; b >= 0; b--) begin
          repeat (h) exp_q.push_back(mk(1'b0, tx_data[b], 1'b0, 8'h00));
          for (int c = 0; c < h; c++)
            exp_q.push_back(mk(1'b1, tx_data[b], (b == 0 && c == 0), sb));
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      ent_t e;
      logic bz;
      bz = (exp_q.size() != 0);
      e  = bz ? exp_q[0] : mk(1'b1, 1'b0, 1'b0, 8'h00);
      chk("R2 R6 sclk", {7'd0, sclk}, {7'd0, e.sclk});
      chk("R3 R5 R10 mosi", {7'd0, mosi}, {7'd0, e.mosi});
      chk("R8 busy", {7'd0, busy}, {7'd0, bz});
      chk("R8 ready", {7'd0, tx_ready}, {7'd0, !bz});
      chk("R7 rx_valid", {7'd0, rx_valid}, {7'd0, e.rx});
      if (e.rx) chk("R4 rx_data", rx_data, e.rxd);
      chk("R9 cs_n", {7'd0, cs_n}, {7'd0, exp_cs_n});
    end
  end

  // slave: shifts MISO on falling SCLK, collects MOSI on rising SCLK
  int         s_fall = 0;
  int         s_rise = 0;
  logic [7:0] s_out = 8'h00;
  logic [7:0] s_in = 8'h00;

  always @(negedge sclk) begin
    if (rst_n) begin
      if (s_fall % 8 == 0) s_out = slave_byte(s_fall / 8);
      miso = s_out[7 - (s_fall % 8)];
      s_fall++;
    end
  end

  always @(posedge sclk) begin
    if (rst_n) begin
      s_in = {s_in[6:0], mosi};
      s_rise++;
      if (s_rise % 8 == 0) begin
        logic [7:0] ex;
        ex = (sent_q.size() != 0) ? sent_q.pop_front() : 8'hxx;
        chk("R3 slave byte", s_in, ex);
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic dl);
    tx_valid = 1'b1;
    tx_data  = d;
    tx_dlm   = dl;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stop_wait();
    tx_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values while held in reset
    chk("R1 sclk", {7'd0, sclk}, 8'd1);
    chk("R1 mosi", {7'd0, mosi}, 8'd0);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 ready", {7'd0, tx_ready}, 8'd1);
    chk("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    chk("R1 cs_n", {7'd0, cs_n}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R7 R8: default divider, back-to-back plain frames
    send(8'hA5, 1'b0);
    send(8'h3C, 1'b0);
    stop_wait();

    // R5: zero delimiter settings clamp to the half-period
    send(8'hC3, 1'b1);
    stop_wait();

    // R5 R9: explicit lengths, chip select raised around the burst
    half_div = 8'd2; guard_len = 8'd5; pulse_len = 8'd3;
    cs_en = 1'b1;
    send(8'hFF, 1'b1);
    send(8'h00, 1'b1);
    send(8'h5A, 1'b0);
    stop_wait();
    cs_en = 1'b0;
    repeat (2) @(negedge clk);

    // R2: divider zero acts as one
    half_div = 8'd0; guard_len = 8'd0; pulse_len = 8'd2;
    send(8'h81, 1'b1);
    send(8'h7E, 1'b0);
    stop_wait();

    // R5 R8: long pulse, minimal guard, offered byte held while busy
    half_div = 8'd1; guard_len = 8'd1; pulse_len = 8'd6;
    cs_en = 1'b1;
    send(8'h01, 1'b1);
    send(8'hE7, 1'b1);
    stop_wait();
    cs_en = 1'b0;
    repeat (4) @(negedge clk);
    summary();
  end

endmodule